// File: doc/BRIEF.md
# Outer-Product Perturbation Bit Array

This block supplies one pseudo-random sign bit to every parameter cell of a learning array laid out in rows and columns. Two independent Galois linear feedback shift registers (LFSRs) drive the array: one supplies a line per row and the other a line per column. Each cell bit is the exclusive-or of the line for its row and the line for its column. The array therefore needs only rows-plus-columns random lines, not one generator per cell.

A learning controller pulses the step input once per learning iteration, and a fresh bit array appears on the next cycle. Between steps the array holds its value, so it can be applied for the whole perturb, measure and update sequence. A seed load sets both generators to known states, which makes learning runs repeatable. By default the array is 6 rows by 7 columns: six weight columns plus one threshold column per neuron row.

Top module: `pert_xor_array`

## Requirements
- R1: After reset the row generator holds 16'hACE1 and the column generator holds 15'h1234, and the array shows the bits formed from those states.
- R2: Output bit index r*COLS+c equals row state bit r XOR column state bit c, for 0 <= r < ROWS and 0 <= c < COLS.
- R3: On a clock edge with stepStrobe high and seedLoad low, the row state takes ROWS Galois right-shifts with feedback mask 16'hB400, and the column state takes COLS Galois right-shifts with mask 15'h6000. In one shift the state moves right by one bit, and the mask is XORed in when the bit shifted out was 1. The new array is visible after that edge.
- R4: With stepStrobe and seedLoad both low, the output does not change.
- R5: On an edge with seedLoad high, the row state takes rowSeed and the column state takes colSeed. A load takes precedence over a step in the same cycle.
- R6: A zero rowSeed loads 16'hACE1 instead, and a zero colSeed loads 15'h1234 instead. Each generator is judged on its own seed.
- R7: Neither generator state is ever all zero.
- R8: Every row of the output array equals row 0 or the bitwise inverse of row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| seedLoad | input | 1 | Load both generator seeds |
| rowSeed | input | 16 | Seed for the row generator (zero selects the default) |
| colSeed | input | 15 | Seed for the column generator (zero selects the default) |
| stepStrobe | input | 1 | Advance to the next perturbation array |
| pertBits | output | ROWS*COLS | Flattened bit array, index r*COLS+c |

## Verification
Random runs mix steps, idle cycles and loads of random seeds. A bench model compares the full 42-bit array after every cycle, so an error in a tap mask, in the shift count or in the row/column bit mapping shows up as a mismatch. Directed cases cover the remaining edge conditions: zero seeds on one generator and on both, which separates correct default substitution from a locked all-zero register, and a load and a step in the same cycle, which shows which of the two wins. Long idle stretches confirm that the array holds its value between steps.

// File: rtl/pert_pkg.sv
package pert_pkg;
  typedef struct packed {
    logic load;
    logic advance;
  } pertCtrl_t;
endpackage

// File: rtl/pert_ctrl.sv
module pert_ctrl
  import pert_pkg::*;
(
  input  logic      seedLoad,
  input  logic      stepStrobe,
  output pertCtrl_t ctrl
);
  always_comb begin
    ctrl.load    = seedLoad;
    ctrl.advance = stepStrobe & ~seedLoad;
  end
endmodule

// File: rtl/pert_lfsr.sv
module pert_lfsr
  import pert_pkg::*;
#(
  parameter int           W       = 16,
  parameter logic [W-1:0] TAPS    = 16'hB400,
  parameter logic [W-1:0] DEFSEED = 16'hACE1,
  parameter int           ADVANCE = 6
) (
  input  logic         clk,
  input  logic         rstN,
  input  pertCtrl_t    ctrl,
  input  logic [W-1:0] seed,
  output logic [W-1:0] state
);
  logic [W-1:0] nextState;
  logic [W-1:0] seedEff;

  function automatic logic [W-1:0] multiShift(input logic [W-1:0] s);
    logic [W-1:0] t;
    t = s;
    for (int i = 0; i < ADVANCE; i++) begin
      if (t[0]) t = (t >> 1) ^ TAPS;
      else      t = t >> 1;
    end
    return t;
  endfunction

  always_comb begin
    seedEff   = (seed == '0) ? DEFSEED : seed;
    nextState = multiShift(state);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            state <= DEFSEED;
    else if (ctrl.load)   state <= seedEff;
    else if (ctrl.advance) state <= nextState;
  end
endmodule

// File: rtl/pert_xor_grid.sv
module pert_xor_grid #(
  parameter int ROWS = 6,
  parameter int COLS = 7
) (
  input  logic [ROWS-1:0]      rowBits,
  input  logic [COLS-1:0]      colBits,
  output logic [ROWS*COLS-1:0] cellBits
);
  for (genvar r = 0; r < ROWS; r++) begin : gRow
    for (genvar c = 0; c < COLS; c++) begin : gCol
      assign cellBits[r*COLS+c] = rowBits[r] ^ colBits[c];
    end
  end
endmodule

// File: rtl/pert_xor_array.sv
module pert_xor_array
  import pert_pkg::*;
#(
  parameter int ROWS  = 6,
  parameter int COLS  = 7,
  parameter int ROW_W = 16,
  parameter int COL_W = 15,
  parameter logic [ROW_W-1:0] ROW_TAPS = 16'hB400,
  parameter logic [COL_W-1:0] COL_TAPS = 15'h6000,
  parameter logic [ROW_W-1:0] ROW_DEF  = 16'hACE1,
  parameter logic [COL_W-1:0] COL_DEF  = 15'h1234
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  seedLoad,
  input  logic [ROW_W-1:0]      rowSeed,
  input  logic [COL_W-1:0]      colSeed,
  input  logic                  stepStrobe,
  output logic [ROWS*COLS-1:0]  pertBits
);
  localparam int CELLS = ROWS * COLS;

  pertCtrl_t        ctrl;
  logic [ROW_W-1:0] rowState;
  logic [COL_W-1:0] colState;
  logic [CELLS-1:0] cellBits;

  pert_ctrl uCtrl (.seedLoad(seedLoad), .stepStrobe(stepStrobe), .ctrl(ctrl));

  pert_lfsr #(.W(ROW_W), .TAPS(ROW_TAPS), .DEFSEED(ROW_DEF), .ADVANCE(ROWS)) uRowGen (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .seed(rowSeed), .state(rowState));

  pert_lfsr #(.W(COL_W), .TAPS(COL_TAPS), .DEFSEED(COL_DEF), .ADVANCE(COLS)) uColGen (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .seed(colSeed), .state(colState));

  pert_xor_grid #(.ROWS(ROWS), .COLS(COLS)) uGrid (
    .rowBits(rowState[ROWS-1:0]), .colBits(colState[COLS-1:0]), .cellBits(cellBits));

  assign pertBits = cellBits;
endmodule

// File: rtl/pert_xor_array_chk.sv
module pert_xor_array_chk #(
  parameter int ROWS  = 6,
  parameter int COLS  = 7,
  parameter int ROW_W = 16,
  parameter int COL_W = 15
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 seedLoad,
  input logic                 stepStrobe,
  input logic [ROW_W-1:0]     rowSeed,
  input logic [COL_W-1:0]     colSeed,
  input logic [ROW_W-1:0]     rowState,
  input logic [COL_W-1:0]     colState,
  input logic [ROWS*COLS-1:0] pertBits
);
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!seedLoad && !stepStrobe) |=> $stable(pertBits)); // R4

  AST_ROW_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    rowState != '0); // R7

  AST_COL_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    colState != '0); // R7

  AST_LOAD_ROW: assert property (@(posedge clk) disable iff (!rstN)
    (seedLoad && rowSeed != '0) |=> rowState == $past(rowSeed)); // R5

  AST_LOAD_COL: assert property (@(posedge clk) disable iff (!rstN)
    (seedLoad && colSeed != '0) |=> colState == $past(colSeed)); // R5

  for (genvar r = 1; r < ROWS; r++) begin : gOuter
    AST_OUTER_ROW: assert property (@(posedge clk) disable iff (!rstN)
      ($countones(pertBits[r*COLS +: COLS] ^ pertBits[0 +: COLS]) == 0) ||
      ($countones(pertBits[r*COLS +: COLS] ^ pertBits[0 +: COLS]) == COLS)); // R8
  end
endmodule

bind pert_xor_array pert_xor_array_chk #(.ROWS(ROWS), .COLS(COLS), .ROW_W(ROW_W), .COL_W(COL_W)) uChk (
  .clk(clk), .rstN(rstN), .seedLoad(seedLoad), .stepStrobe(stepStrobe),
  .rowSeed(rowSeed), .colSeed(colSeed), .rowState(rowState), .colState(colState),
  .pertBits(pertBits));

// File: tb/pert_xor_array_test.sv
module pert_xor_array_test;
  localparam int ROWS = 6;
  localparam int COLS = 7;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        seedLoad = 1'b0;
  logic [15:0] rowSeed = '0;
  logic [14:0] colSeed = '0;
  logic        stepStrobe = 1'b0;
  logic [ROWS*COLS-1:0] pertBits;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [15:0] mRow;
  logic [14:0] mCol;

  always #2 clk = ~clk;

  pert_xor_array uut (.clk(clk), .rstN(rstN), .seedLoad(seedLoad), .rowSeed(rowSeed),
    .colSeed(colSeed), .stepStrobe(stepStrobe), .pertBits(pertBits));

  function automatic logic [15:0] rowAdv(input logic [15:0] s);
    logic [15:0] t = s;
    for (int i = 0; i < ROWS; i++) t = t[0] ? ((t >> 1) ^ 16'hB400) : (t >> 1);
    return t;
  endfunction

  function automatic logic [14:0] colAdv(input logic [14:0] s);
    logic [14:0] t = s;
    for (int i = 0; i < COLS; i++) t = t[0] ? ((t >> 1) ^ 15'h6000) : (t >> 1);
    return t;
  endfunction

  function automatic logic [ROWS*COLS-1:0] expArray(input logic [15:0] r, input logic [14:0] c);
    logic [ROWS*COLS-1:0] v;
    for (int i = 0; i < ROWS; i++)
      for (int j = 0; j < COLS; j++) v[i*COLS+j] = r[i] ^ c[j];
    return v;
  endfunction

  task automatic compare(input string req);
    logic [ROWS*COLS-1:0] e = expArray(mRow, mCol);
    checks++;
    if (pertBits !== e) begin
      fails++;
      $display("FAIL %s: pertBits=%h expected=%h", req, pertBits, e);
    end
  endtask

  task automatic cyc(input logic ld, input logic [15:0] rs, input logic [14:0] cs,
                     input logic st, input string req);
    seedLoad = ld; rowSeed = rs; colSeed = cs; stepStrobe = st;
    @(posedge clk);
    if (ld) begin
      mRow = (rs == 0) ? 16'hACE1 : rs;
      mCol = (cs == 0) ? 15'h1234 : cs;
    end else if (st) begin
      mRow = rowAdv(mRow);
      mCol = colAdv(mCol);
    end
    @(negedge clk);
    seedLoad = 1'b0; stepStrobe = 1'b0;
    compare(req);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: run expired, expected completion");
    finishRun();
  end

  initial begin
    void'($urandom(32'd7781));
    mRow = 16'hACE1; mCol = 15'h1234;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    compare("R1 R2 reset array");
    // R3 R8: consecutive steps from reset seed
    for (int i = 0; i < 20; i++) cyc(1'b0, '0, '0, 1'b1, "R3 R8 step");
    // R4: idle holds
    for (int i = 0; i < 10; i++) cyc(1'b0, 16'hFFFF, 15'h7FFF, 1'b0, "R4 idle hold");
    // R5: explicit seeds
    cyc(1'b1, 16'h0001, 15'h0001, 1'b0, "R5 load");
    cyc(1'b0, '0, '0, 1'b1, "R3 step after load");
    // R5: load wins over step
    cyc(1'b1, 16'h8421, 15'h2A55, 1'b1, "R5 load over step");
    // R6 R7: zero seeds replaced
    cyc(1'b1, 16'h0000, 15'h0003, 1'b0, "R6 R7 zero row seed");
    cyc(1'b1, 16'h00F0, 15'h0000, 1'b0, "R6 R7 zero col seed");
    cyc(1'b1, 16'h0000, 15'h0000, 1'b1, "R6 R7 both zero");
    for (int i = 0; i < 5; i++) cyc(1'b0, '0, '0, 1'b1, "R3 R7 step after default");
    // random mix
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 9);
      logic [15:0] rs = ($urandom_range(0, 7) == 0) ? 16'h0 : 16'($urandom());
      logic [14:0] cs = ($urandom_range(0, 7) == 0) ? 15'h0 : 15'($urandom());
      if (k == 0)      cyc(1'b1, rs, cs, 1'($urandom_range(0, 1)), "R5 R6 random load");
      else if (k < 4)  cyc(1'b0, rs, cs, 1'b0, "R4 random idle");
      else             cyc(1'b0, rs, cs, 1'b1, "R2 R3 R8 random step");
    end
    // reset again mid-run
    rstN = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mRow = 16'hACE1; mCol = 15'h1234;
    compare("R1 re-reset");
    finishRun();
  end
endmodule